// File: doc/BRIEF.md
# Frequency Synthesizer Lock Controller

This block sits on the register side of one frequency-synthesizer channel. Software writes a divider setting, a multiplier setting and a settling count through a valid/ready write port in the main clock domain. The block keeps the active divider and multiplier values and drives the enable of the analog multiplier. It also drives a flag that tells the clock path to hold its output at a constant high level while the divider is zero. The channel's frequency ratio is (multiplier + 1) / divider, and both fields are visible at the outputs.

When a write changes the divider or the multiplier, the lock status bit drops in the main domain at once. The request then crosses into the slow reference-clock domain through a toggle handshake. There, a countdown timer is reloaded with the programmed settling count and decremented once per slow-clock cycle. When the count runs out, the completion crosses back and sets the lock bit. The interrupt request is a level equal to the lock bit gated by an interrupt enable.

The write port accepts a beat when `wr_valid` and `wr_ready` are both high at a rising edge of `clk`. A beat that changes a parameter holds `wr_ready` low until the slow domain has taken the request. The write data must stay steady while `wr_valid` is high and `wr_ready` is low.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset: `div_q` = 0, `mul_q` = 0, `div_bypass` = 1, `mult_en` = 0, `locked` = 0, `irq` = 0 and `wr_ready` = 1.
- R2: A beat is accepted when `wr_valid` and `wr_ready` are high at a `clk` edge. An accepted beat that changes a parameter appears on `div_q`/`mul_q` one cycle later. It drives `wr_ready` low until the slow domain has acknowledged it.
- R3: `div_bypass` is 1 exactly when `div_q` is 0. Divider values 1 to 255 give `div_bypass` = 0.
- R4: `mult_en` is 1 exactly when `mul_q` is nonzero. The ratio (`mul_q` + 1) / `div_q` can be read from the two outputs.
- R5: An accepted beat whose `wr_div` or `wr_mul` differs from the held value clears `locked` in the cycle after acceptance.
- R6: After such a change with a nonzero multiplier and settling count C, `locked` stays 0 for at least C slow-clock cycles after acceptance. It becomes 1 within C + 8 slow-clock cycles. A count of 0 locks after the crossing delay alone.
- R7: While `mul_q` is 0, `locked` stays 0 and the timer stays idle.
- R8: An accepted beat with the same divider and multiplier as held changes nothing. `locked` keeps its value, `wr_ready` stays 1 and its count is discarded.
- R9: A parameter change during a running countdown restarts the timer from the new count. The old countdown does not set `locked`.
- R10: `irq` equals `locked` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main (register) clock |
| slow_clk | input | 1 | Slow reference clock for the settling timer |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write port can take a beat |
| wr_div | input | 8 | Divider value, 0 = constant-high bypass |
| wr_mul | input | 8 | Multiplier value, 0 = multiplier off |
| wr_count | input | 8 | Settling count in slow-clock cycles |
| irq_en | input | 1 | Interrupt enable |
| div_q | output | 8 | Active divider value |
| mul_q | output | 8 | Active multiplier value |
| div_bypass | output | 1 | Divider zero: output forced high |
| mult_en | output | 1 | Analog multiplier enable |
| locked | output | 1 | Lock status |
| irq | output | 1 | Interrupt request level |

## Verification
Directed writes cover several cases: a normal change with a short count, a repeat of the held values (which must leave lock untouched), a zero divider, a zero multiplier and a zero count. Each case separates one decision of the change detector or the timer. A restart case rewrites the multiplier halfway through a long countdown and samples lock after the point where the stale countdown would have ended. This tells a reloading timer apart from one that lets the first count finish. Random divider, multiplier and count values then probe the lower and upper lock-time bounds and the field, bypass and enable outputs across the value range.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  parameter int DIV_W = 8;
  parameter int MUL_W = 8;
  parameter int CNT_W = 8;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [MUL_W-1:0] mul;
    logic [CNT_W-1:0] cnt;
  } pll_wr_t;
endpackage

// File: rtl/pll_tgl_sync.sv
module pll_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pll_wr_port.sv
module pll_wr_port
  import pll_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  pll_wr_t          wr_in,
  input  logic             ack_s,
  input  logic             done_s,
  output logic [DIV_W-1:0] div_q,
  output logic [MUL_W-1:0] mul_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             req_tgl,
  output logic             locked
);
  logic busy, ack_seen, done_seen;
  logic accept, change, ack_edge, done_edge;

  assign wr_ready  = !busy;
  assign accept    = wr_valid && !busy;
  assign change    = accept && ((wr_in.div != div_q) || (wr_in.mul != mul_q));
  assign ack_edge  = ack_s ^ ack_seen;
  assign done_edge = done_s ^ done_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      mul_q     <= '0;
      cnt_q     <= '0;
      req_tgl   <= 1'b0;
      busy      <= 1'b0;
      locked    <= 1'b0;
      ack_seen  <= 1'b0;
      done_seen <= 1'b0;
    end else begin
      ack_seen  <= ack_s;
      done_seen <= done_s;
      if (change) begin
        div_q   <= wr_in.div;
        mul_q   <= wr_in.mul;
        cnt_q   <= wr_in.cnt;
        req_tgl <= ~req_tgl;
        busy    <= 1'b1;
        locked  <= 1'b0;
      end else begin
        if (ack_edge) busy <= 1'b0;
        if (done_edge && !busy && (mul_q != '0)) locked <= 1'b1;
      end
    end
  end

  assert_lock_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && ((wr_in.div != div_q) || (wr_in.mul != mul_q))) |=> !locked);

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && ((wr_in.div != div_q) || (wr_in.mul != mul_q))) |=> !wr_ready);

  assert_lock_needs_mult_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (mul_q != '0));

  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> ($stable(div_q) && $stable(mul_q)));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
  import pll_lock_pkg::*;
(
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             mul_nz,
  output logic             ack_tgl,
  output logic             done_tgl
);
  logic             req_prev, active, load;
  logic [CNT_W-1:0] cnt;

  assign load    = req_s ^ req_prev;
  assign ack_tgl = req_prev;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      done_tgl <= 1'b0;
    end else begin
      req_prev <= req_s;
      if (load) begin
        cnt    <= cnt_in;
        active <= mul_nz;
      end else if (active) begin
        if (cnt == '0) begin
          active   <= 1'b0;
          done_tgl <= ~done_tgl;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_count_down_R6: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (active && !load && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));

  assert_idle_when_off_R7: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (load && !mul_nz) |=> (!active && $stable(done_tgl)));
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DIV_W-1:0] wr_div,
  input  logic [MUL_W-1:0] wr_mul,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             irq_en,
  output logic [DIV_W-1:0] div_q,
  output logic [MUL_W-1:0] mul_q,
  output logic             div_bypass,
  output logic             mult_en,
  output logic             locked,
  output logic             irq
);
  pll_wr_t          wr_in;
  logic [CNT_W-1:0] cnt_q;
  logic             req_tgl, req_s, ack_tgl, ack_s, done_tgl, done_s;

  assign wr_in = '{div: wr_div, mul: wr_mul, cnt: wr_count};

  pll_wr_port u_port (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_in(wr_in), .ack_s(ack_s), .done_s(done_s), .div_q(div_q),
    .mul_q(mul_q), .cnt_q(cnt_q), .req_tgl(req_tgl), .locked(locked)
  );

  pll_tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(slow_clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  pll_lock_timer u_timer (
    .slow_clk(slow_clk), .rst_n(rst_n), .req_s(req_s), .cnt_in(cnt_q),
    .mul_nz(mult_en), .ack_tgl(ack_tgl), .done_tgl(done_tgl)
  );

  pll_tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  pll_tgl_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d(done_tgl), .q(done_s)
  );

  assign div_bypass = (div_q == '0);
  assign mult_en    = (mul_q != '0);
  assign irq        = locked && irq_en;
endmodule

// File: tb/tb_pll_lock_ctrl.sv
`timescale 1ns/1ps
module tb_pll_lock_ctrl;
  logic clk = 0, slow_clk = 0, rst_n = 0;
  logic wr_valid = 0, irq_en = 0;
  logic [7:0] wr_div = 0, wr_mul = 0, wr_count = 0;
  logic wr_ready, div_bypass, mult_en, locked, irq;
  logic [7:0] div_q, mul_q;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] cur_div = 0, cur_mul = 0;

  always #2.5 clk = ~clk;
  always #40 slow_clk = ~slow_clk;

  pll_lock_ctrl dut (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_div(wr_div), .wr_mul(wr_mul), .wr_count(wr_count),
    .irq_en(irq_en), .div_q(div_q), .mul_q(mul_q), .div_bypass(div_bypass),
    .mult_en(mult_en), .locked(locked), .irq(irq)
  );

  function automatic logic exp_bypass(logic [7:0] d); return d == 0; endfunction
  function automatic logic exp_mult_en(logic [7:0] m); return m != 0; endfunction
  function automatic logic exp_irq(logic l, logic e); return l && e; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slow_wait(int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  // Drive one beat and return at the negedge after the accepting edge.
  task automatic write(logic [7:0] d, logic [7:0] m, logic [7:0] c);
    wr_valid = 1; wr_div = d; wr_mul = m; wr_count = c;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
    cur_div = d; cur_mul = m;
  endtask

  // Change with lock expected: fields, clear, lower and upper lock bounds.
  task automatic change_and_lock(logic [7:0] d, logic [7:0] m, logic [7:0] c);
    write(d, m, c);
    check("R2 div_q", div_q, d);
    check("R2 mul_q", mul_q, m);
    check("R2 ready low", wr_ready, 0);
    check("R3 bypass", div_bypass, exp_bypass(d));
    check("R4 mult_en", mult_en, exp_mult_en(m));
    check("R5 lock cleared", locked, 0);
    if (c > 0) begin
      slow_wait(c);
      check("R6 no early lock", locked, 0);
      slow_wait(8);
    end else begin
      slow_wait(8);
    end
    check("R6 locked", locked, 1);
    check("R10 irq", irq, exp_irq(1, irq_en));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 div_q", div_q, 0);
    check("R1 mul_q", mul_q, 0);
    check("R1 bypass", div_bypass, 1);
    check("R1 mult_en", mult_en, 0);
    check("R1 locked", locked, 0);
    check("R1 irq", irq, 0);
    check("R1 ready", wr_ready, 1);

    // Normal change, irq masked then enabled (R10)
    change_and_lock(8'd4, 8'd9, 8'd5);
    check("R10 irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    check("R10 irq enabled", irq, 1);

    // R8: same div/mul, count ignored
    write(8'd4, 8'd9, 8'd50);
    check("R8 ready stays", wr_ready, 1);
    check("R8 lock kept", locked, 1);
    slow_wait(10);
    check("R8 lock still kept", locked, 1);

    // R3: zero divider bypass, divider 255 not bypassed
    change_and_lock(8'd0, 8'd9, 8'd3);
    check("R3 bypass on zero", div_bypass, 1);
    change_and_lock(8'd255, 8'd9, 8'd2);

    // R7: multiplier off
    write(8'd255, 8'd0, 8'd2);
    check("R7 mult_en off", mult_en, 0);
    check("R7 lock clear", locked, 0);
    slow_wait(30);
    check("R7 lock stays clear", locked, 0);
    check("R7 irq clear", irq, 0);

    // R6: zero count, re-enable
    change_and_lock(8'd2, 8'd3, 8'd0);

    // R9: restart during countdown
    write(8'd2, 8'd5, 8'd60);
    slow_wait(30);
    check("R9 mid countdown", locked, 0);
    write(8'd2, 8'd6, 8'd40);
    slow_wait(36);
    check("R9 old count ignored", locked, 0);
    slow_wait(12);
    check("R9 locked after new count", locked, 1);

    // Random writes, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 10; i++) begin
      logic [7:0] d, m, c;
      d = 8'($urandom_range(0, 255));
      m = 8'($urandom_range(1, 255));
      c = 8'($urandom_range(0, 20));
      if (d == cur_div && m == cur_mul) m = m + 8'd1;
      if (m == 0) m = 8'd1;
      irq_en = 1'($urandom_range(0, 1));
      change_and_lock(d, m, c);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule